// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This block is the address front end of an I2C slave. It brings the bus lines SCL and SDA into the system clock domain and finds START, repeated START and STOP conditions. It shifts in the address phase with the most significant bit first and decides whether this device is the target of the transfer. When it is, it acknowledges by pulling SDA low during the ninth SCL clock. The pull-down is modelled as an output enable, so the pad drives zero while `sdaOe` is high and is released otherwise.

A per-bit mask lets one slave answer a group of addresses. A mask bit of 1 makes the matching address bit a don't-care. The unit accepts a 7-bit address in one byte, or a 10-bit address sent as a header byte followed by a low byte. It can also accept the general call address. After an address is accepted, the user side sees `addressed`, `generalCallHit` and the R/W direction. Data bytes that follow the address are left to other logic. The system clock should run at least 16 times faster than SCL, and SCL may run at up to 1 MHz.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sdaOe`, `addressed`, `generalCallHit` and `rwBit` are all 0.
- R2: When `tenBitMode`=0, the unit compares the first byte after a START as follows: byte bits [7:1] against `ownAddr[6:0]`. On a match it pulls SDA low during the ninth SCL clock and sets `addressed`=1. It also sets `rwBit` to byte bit 0 (1 = read), and `rwBit` holds steady while `addressed` stays 1.
- R3: When the first byte does not match, `sdaOe` stays 0 through the ninth clock and `addressed` stays 0.
- R4: An `addrMask` bit of 1 removes the address bit with the same index from the comparison. Bits whose mask bit is 0 must still be equal.
- R5: When `gcEnable`=1, a first byte of 0x00 is acknowledged and sets both `addressed` and `generalCallHit`. When `gcEnable`=0, the same byte is acknowledged only if the masked own address matches. In that case `addressed`=1 and `generalCallHit`=0. `generalCallHit` is never 1 while `addressed` is 0.
- R6: When `tenBitMode`=1, a header byte of 11110, `ownAddr[9:8]`, R/W=0 with a masked match is acknowledged, while `addressed` stays 0. The next byte is then compared with `ownAddr[7:0]` under the mask. A match is acknowledged and sets `addressed`=1 with `rwBit`=0. A mismatch, or a header with the wrong upper bits, gets no acknowledge.
- R7: After a completed 10-bit write selection, a repeated START followed by a matching header with R/W=1 is acknowledged and sets `addressed`=1 with `rwBit`=1. If that selection was cancelled by a STOP, the same header gets no acknowledge.
- R8: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) clears `addressed`, `generalCallHit` and `rwBit` and restarts address capture. A STOP also forgets the 10-bit selection.
- R9: `sdaOe` rises only after the eighth SCL falling edge and falls after the ninth SCL falling edge. Both changes happen while SCL is low.
- R10: Bits clocked on the bus before any START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL bus level |
| sdaIn | input | 1 | SDA bus level |
| tenBitMode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gcEnable | input | 1 | 1 = accept the general call address |
| ownAddr | input | 10 | Own slave address (bits [6:0] used in 7-bit mode) |
| addrMask | input | 10 | 1 = the address bit is not compared |
| sdaOe | output | 1 | 1 = drive SDA low (acknowledge) |
| addressed | output | 1 | The device was selected in the current transfer |
| generalCallHit | output | 1 | The selection was made by the general call address |
| rwBit | output | 1 | Direction of the selection, 1 = read |

## Verification
One address byte can hit the masked own-address comparison and the general call detector at once. This happens when the mask covers every 7-bit address bit and 0x00 is sent. The bench provokes this case with `gcEnable` both set and clear. It expects an acknowledge each time, with `generalCallHit` following `gcEnable` alone. A repeated START can also clear `addressed` at the same moment that the 10-bit selection must survive. The bench sends a repeated START after a 10-bit write and checks two things: the flag drops at once, and the following read header is still accepted.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  localparam int ADDR_W    = 10;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 2);

  typedef struct packed {
    logic shiftEn;
    logic cntEn;
    logic cntClr;
  } dpCtrl_t;

  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic ackDone;
    logic ownMatch7;
    logic genCall;
    logic hdrMatch;
    logic lowMatch;
    logic rwIn;
  } dpStat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_ACK,
    ST_DONE,
    ST_SKIP
  } addrState_t;

endpackage

// File: rtl/i2c_addr_dp.sv
module i2c_addr_dp
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat
);

  // Synchroniser stages plus one history stage for edge detection.
  logic [SYNC_STAGES:0]   sclPipe;
  logic [SYNC_STAGES:0]   sdaPipe;
  logic [BYTE_BITS-1:0]   shiftReg;
  logic [CNT_W-1:0]       bitCnt;
  logic                   sclNow, sclOld, sdaNow, sdaOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sclOld = sclPipe[SYNC_STAGES];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];
  assign sdaOld = sdaPipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctrl.shiftEn && stat.sclRise)
        shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaNow};
      if (ctrl.cntClr)
        bitCnt <= '0;
      else if (ctrl.cntEn && stat.sclRise)
        bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    stat.sclRise   = sclNow && !sclOld;
    stat.sclFall   = !sclNow && sclOld;
    stat.startSeen = sclNow && sclOld && sdaOld && !sdaNow;
    stat.stopSeen  = sclNow && sclOld && !sdaOld && sdaNow;
    stat.byteDone  = (bitCnt == CNT_W'(BYTE_BITS));
    stat.ackDone   = (bitCnt == CNT_W'(BYTE_BITS + 1));
    stat.ownMatch7 = (((shiftReg[7:1] ^ ownAddr[6:0]) & ~addrMask[6:0]) == '0);
    stat.hdrMatch  = (shiftReg[7:3] == 5'b11110) &&
                     (((shiftReg[2:1] ^ ownAddr[9:8]) & ~addrMask[9:8]) == '0);
    stat.lowMatch  = (((shiftReg ^ ownAddr[7:0]) & ~addrMask[7:0]) == '0);
    stat.genCall   = (shiftReg == '0);
    stat.rwIn      = shiftReg[0];
  end

endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tenBitMode,
  input  logic    gcEnable,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    sdaOe,
  output logic    addressed,
  output logic    generalCallHit,
  output logic    rwBit
);

  addrState_t state;
  logic tenSel, hdrPend;
  logic take, setAdr, gcOk, hdrNext, selSet, selClr;

  always_comb begin
    ctrl.shiftEn = (state == ST_ADDR1) || (state == ST_ADDR2);
    ctrl.cntEn   = ctrl.shiftEn || (state == ST_ACK);
    ctrl.cntClr  = stat.startSeen || stat.stopSeen ||
                   ((state == ST_ACK) && stat.sclFall && stat.ackDone);
  end

  // Decision for a completed byte.
  always_comb begin
    gcOk    = stat.genCall && gcEnable;
    take    = 1'b0;
    setAdr  = 1'b0;
    hdrNext = 1'b0;
    selSet  = 1'b0;
    selClr  = 1'b0;
    if (state == ST_ADDR1) begin
      if (gcOk) begin
        take   = 1'b1;
        setAdr = 1'b1;
      end else if (!tenBitMode) begin
        take   = stat.ownMatch7;
        setAdr = stat.ownMatch7;
      end else if (stat.hdrMatch && !stat.rwIn) begin
        take    = 1'b1;
        hdrNext = 1'b1;
        selClr  = 1'b1;
      end else if (stat.hdrMatch && stat.rwIn && tenSel) begin
        take   = 1'b1;
        setAdr = 1'b1;
      end
    end else if (state == ST_ADDR2) begin
      take   = stat.lowMatch;
      setAdr = stat.lowMatch;
      selSet = stat.lowMatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      tenSel         <= 1'b0;
      hdrPend        <= 1'b0;
      sdaOe          <= 1'b0;
      addressed      <= 1'b0;
      generalCallHit <= 1'b0;
      rwBit          <= 1'b0;
    end else if (stat.startSeen) begin
      state          <= ST_ADDR1;
      hdrPend        <= 1'b0;
      sdaOe          <= 1'b0;
      addressed      <= 1'b0;
      generalCallHit <= 1'b0;
      rwBit          <= 1'b0;
    end else if (stat.stopSeen) begin
      state          <= ST_IDLE;
      tenSel         <= 1'b0;
      hdrPend        <= 1'b0;
      sdaOe          <= 1'b0;
      addressed      <= 1'b0;
      generalCallHit <= 1'b0;
      rwBit          <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR1, ST_ADDR2: begin
          if (stat.sclFall && stat.byteDone) begin
            if (take) begin
              state   <= ST_ACK;
              sdaOe   <= 1'b1;
              hdrPend <= hdrNext;
              if (selSet) tenSel <= 1'b1;
              if (selClr) tenSel <= 1'b0;
              if (setAdr) begin
                addressed      <= 1'b1;
                generalCallHit <= gcOk && (state == ST_ADDR1);
                rwBit          <= (state == ST_ADDR1) ? stat.rwIn : 1'b0;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (stat.sclFall && stat.ackDone) begin
            sdaOe   <= 1'b0;
            hdrPend <= 1'b0;
            state   <= hdrPend ? ST_ADDR2 : ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              tenBitMode,
  input  logic              gcEnable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  output logic              sdaOe,
  output logic              addressed,
  output logic              generalCallHit,
  output logic              rwBit
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  i2c_addr_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ownAddr  (ownAddr),
    .addrMask (addrMask),
    .ctrl     (dpCtrl),
    .stat     (dpStat)
  );

  i2c_addr_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .tenBitMode     (tenBitMode),
    .gcEnable       (gcEnable),
    .stat           (dpStat),
    .ctrl           (dpCtrl),
    .sdaOe          (sdaOe),
    .addressed      (addressed),
    .generalCallHit (generalCallHit),
    .rwBit          (rwBit)
  );

endmodule

// File: rtl/i2c_addr_chk.sv
module i2c_addr_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic addressed,
  input logic generalCallHit,
  input logic rwBit,
  input logic startSeen,
  input logic stopSeen
);

  p_ack_low_phase_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !sclIn);

  p_gc_needs_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    generalCallHit |-> addressed);

  p_addr_with_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addressed) |-> sdaOe);

  p_rw_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addressed && $past(addressed)) |-> $stable(rwBit));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!addressed && !sdaOe && !generalCallHit));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (!addressed && !generalCallHit && !rwBit));

endmodule

bind i2c_addr_match i2c_addr_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .sclIn          (sclIn),
  .sdaOe          (sdaOe),
  .addressed      (addressed),
  .generalCallHit (generalCallHit),
  .rwBit          (rwBit),
  .startSeen      (dpStat.startSeen),
  .stopSeen       (dpStat.stopSeen)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;   // system clocks per SCL quarter period

  typedef struct {
    bit    ack;
    bit    adr;
    bit    gc;
    bit    rw;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic       tenBitMode = 1'b0;
  logic       gcEnable = 1'b0;
  logic [9:0] ownAddr = 10'h02A;
  logic [9:0] addrMask = 10'h000;
  logic       sdaOe, addressed, generalCallHit, rwBit;
  logic       sdaBus;

  int checks = 0;
  int fails  = 0;

  expItem_t expQ[$];
  bit obsAck, obsAdr, obsGc, obsRw;
  event obsEv;

  assign sdaBus = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match u0 (
    .clk            (clk),
    .rstN           (rstN),
    .sclIn          (mScl),
    .sdaIn          (sdaBus),
    .tenBitMode     (tenBitMode),
    .gcEnable       (gcEnable),
    .ownAddr        (ownAddr),
    .addrMask       (addrMask),
    .sdaOe          (sdaOe),
    .addressed      (addressed),
    .generalCallHit (generalCallHit),
    .rwBit          (rwBit)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(1);
    mScl = 1'b1; waitQ(1);
    mSda = 1'b0; waitQ(1);
    mScl = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(1);
    mScl = 1'b1; waitQ(1);
    mSda = 1'b1; waitQ(1);
  endtask

  // Driver: pushes the expected outcome, then clocks the byte and ACK bit.
  task automatic sendByte(input logic [7:0] b, input bit ack, input bit adr,
                          input bit gc, input bit rw, input string tag);
    expItem_t it;
    it.ack = ack; it.adr = adr; it.gc = gc; it.rw = rw; it.tag = tag;
    expQ.push_back(it);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(1);
      mScl = 1'b1; waitQ(2);
      mScl = 1'b0; waitQ(1);
    end
    mSda = 1'b1; waitQ(1);
    mScl = 1'b1; waitQ(1);
    obsAck = !sdaBus; obsAdr = addressed; obsGc = generalCallHit; obsRw = rwBit;
    -> obsEv;
    waitQ(1);
    mScl = 1'b0; waitQ(1);
  endtask

  // Monitor: compares each observed ACK slot against the queue head.
  initial begin
    forever begin
      expItem_t e;
      @obsEv;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected observation actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        check({e.tag, " ack"}, obsAck, e.ack);
        check({e.tag, " addressed"}, obsAdr, e.adr);
        check({e.tag, " generalCallHit"}, obsGc, e.gc);
        check({e.tag, " rwBit"}, obsRw, e.rw);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R1 sdaOe", sdaOe, 1'b0);
    check("R1 addressed", addressed, 1'b0);
    check("R1 generalCallHit", generalCallHit, 1'b0);
    check("R1 rwBit", rwBit, 1'b0);
    rstN = 1'b1;
    waitQ(2);

    // R10: byte clocked with no START in front of it
    mScl = 1'b0; waitQ(1);
    sendByte(8'h54, 0, 0, 0, 0, "R10 no start");
    busStop();

    // R2: 7-bit write and read
    busStart();
    sendByte(8'h54, 1, 1, 0, 0, "R2 write");
    check("R9 released after ninth clock", sdaOe, 1'b0);
    check("R2 addressed held", addressed, 1'b1);
    busStop();
    check("R8 stop clears addressed", addressed, 1'b0);
    busStart();
    sendByte(8'h55, 1, 1, 0, 1, "R2 read");
    busStop();

    // R3: mismatch
    busStart();
    sendByte(8'h56, 0, 0, 0, 0, "R3 mismatch");
    busStop();

    // R4: mask low two bits
    addrMask = 10'h003;
    busStart();
    sendByte(8'h56, 1, 1, 0, 0, "R4 masked bit0");
    busStop();
    busStart();
    sendByte(8'h58, 0, 0, 0, 0, "R4 unmasked bit2");
    busStop();
    addrMask = 10'h000;

    // R5: general call
    gcEnable = 1'b1;
    busStart();
    sendByte(8'h00, 1, 1, 1, 0, "R5 gc on");
    busStop();
    gcEnable = 1'b0;
    busStart();
    sendByte(8'h00, 0, 0, 0, 0, "R5 gc off");
    busStop();

    // R5 with R4: both detectors hit 0x00
    addrMask = 10'h07F;
    gcEnable = 1'b1;
    busStart();
    sendByte(8'h00, 1, 1, 1, 0, "R5 both hit gc on");
    busStop();
    gcEnable = 1'b0;
    busStart();
    sendByte(8'h00, 1, 1, 0, 0, "R5 both hit gc off");
    busStop();
    addrMask = 10'h000;

    // R6: 10-bit write, address 0x2D5
    tenBitMode = 1'b1;
    ownAddr    = 10'h2D5;
    busStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R6 header");
    sendByte(8'hD5, 1, 1, 0, 0, "R6 low byte");
    // R7: repeated START then read header
    busStart();
    check("R8 restart clears addressed", addressed, 1'b0);
    sendByte(8'hF5, 1, 1, 0, 1, "R7 read reselect");
    busStop();
    busStart();
    sendByte(8'hF5, 0, 0, 0, 0, "R7 read after stop");
    busStop();

    busStart();
    sendByte(8'hF4, 1, 0, 0, 0, "R6 header again");
    sendByte(8'hD4, 0, 0, 0, 0, "R6 low mismatch");
    busStop();
    busStart();
    sendByte(8'hF6, 0, 0, 0, 0, "R6 header mismatch");
    busStop();

    gcEnable = 1'b1;
    busStart();
    sendByte(8'h00, 1, 1, 1, 0, "R5 gc in ten-bit mode");
    busStop();

    waitQ(2);
    check("R3 queue drained", expQ.size() == 0, 1'b1);
    finishRun();
  end

endmodule